// File: doc/BRIEF.md
# Deblocking Edge Strength Decision Unit

This block decides how hard a deblocking filter should smooth one edge between two neighbouring 4x4 blocks of a decoded picture. For each side of the edge (called P and Q) it takes an intra-coded flag, a coded-coefficient flag, a count of reference pictures, a reference picture identifier per prediction list and a motion vector per prediction list. Three more flags describe the edge itself: whether it lies on a macroblock border, whether it lies on the picture border, and whether filtering has been switched off for it.

The decision is made in a fixed order of priority. An edge that must not be filtered comes first, then intra coding, then coded coefficients, and then differences in motion. The result is a 3-bit strength from 0 to 4 and is captured in an output register whenever the edge-valid input is high. The register is copied to a second output for the chroma edge at the same position. A filter controller presents one edge per cycle and reads the strength one clock later.

Top module: `edge_strength_unit`

## Requirements
- R1: When either block is intra coded, the edge is a macroblock border and filtering is allowed, the strength is 4.
- R2: When either block is intra coded, the edge lies inside a macroblock and filtering is allowed, the strength is 3.
- R3: When neither block is intra coded and at least one has coded coefficients, the strength is 2.
- R4: Otherwise the strength is 1 if the two reference counts differ, or if the counts are equal and the reference identifiers differ for any list index below the P count.
- R5: Otherwise the strength is 1 if, for any list index below the P count, the horizontal or the vertical motion vector component differs by 4 or more in absolute value (quarter-sample units, two's complement). Lists at or above the count are not compared.
- R6: When none of R1 to R5 applies, the strength is 0.
- R7: An edge flagged as a picture border, or with filtering switched off, gets strength 0 whatever the block flags are.
- R8: The chroma strength output always equals the luma strength output.
- R9: The strength of an edge presented with edge_vld high appears on the outputs at the next rising clock edge. While edge_vld is low the outputs hold their value.
- R10: During reset and after its release both outputs read 0 until an edge is loaded. Reset is asserted asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_vld | input | 1 | Load enable for the strength register |
| mb_edge | input | 1 | Edge lies on a macroblock border |
| pic_edge | input | 1 | Edge lies on the picture border |
| filt_off | input | 1 | Filtering disabled for this edge |
| p_intra | input | 1 | P block is intra coded |
| q_intra | input | 1 | Q block is intra coded |
| p_coded | input | 1 | P block has coded coefficients |
| q_coded | input | 1 | Q block has coded coefficients |
| p_nref | input | CW (2) | Number of reference pictures used by P |
| q_nref | input | CW (2) | Number of reference pictures used by Q |
| p_ref | input | NL*RW (10) | P reference identifiers, list i at bits i*RW |
| q_ref | input | NL*RW (10) | Q reference identifiers |
| p_mvx | input | NL*MW (24) | P horizontal motion vectors, signed, list i at bits i*MW |
| p_mvy | input | NL*MW (24) | P vertical motion vectors |
| q_mvx | input | NL*MW (24) | Q horizontal motion vectors |
| q_mvy | input | NL*MW (24) | Q vertical motion vectors |
| bs_luma | output | 3 | Registered luma edge strength |
| bs_chroma | output | 3 | Registered chroma edge strength |

## Verification
The bench aims at the priority boundaries. It checks intra coding on a border edge against an inner edge: a design that ignored mb_edge would report 3 where 4 is due. It also checks an intra block on a picture border: a wrong order of priority would report 4 there instead of 0. Motion differences of exactly 3 and 4 are tried in both signs and on both components, so an off-by-one threshold or a missing absolute value shows up as a wrong 0 or 1. A difference placed only in a list beyond the reference count must give 0, and edge_vld low must leave the last strength in place.

// File: rtl/edge_strength_pkg.sv
package edge_strength_pkg;
  localparam int BS_W = 3;

  typedef enum logic [BS_W-1:0] {
    BS_NONE     = 3'd0,
    BS_MOTION   = 3'd1,
    BS_CODED    = 3'd2,
    BS_INTRA_IN = 3'd3,
    BS_INTRA_MB = 3'd4
  } bs_t;
endpackage

// File: rtl/es_rst_sync.sv
module es_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/es_mv_cmp.sv
// Flags a motion vector pair whose components are far apart.
module es_mv_cmp #(
  parameter int MW  = 12,
  parameter int THR = 4
) (
  input  logic [MW-1:0] a_x,
  input  logic [MW-1:0] a_y,
  input  logic [MW-1:0] b_x,
  input  logic [MW-1:0] b_y,
  output logic          far
);
  localparam logic [MW:0] THR_V = (MW+1)'(THR);

  logic [MW:0] dx, dy, ax, ay;

  always_comb begin
    dx  = {a_x[MW-1], a_x} - {b_x[MW-1], b_x};
    dy  = {a_y[MW-1], a_y} - {b_y[MW-1], b_y};
    ax  = dx[MW] ? (~dx + 1'b1) : dx;
    ay  = dy[MW] ? (~dy + 1'b1) : dy;
    far = (ax >= THR_V) || (ay >= THR_V);
  end
endmodule

// File: rtl/es_motion_cmp.sv
// Compares references and motion for the lists in use.
module es_motion_cmp #(
  parameter int NL  = 2,
  parameter int RW  = 5,
  parameter int MW  = 12,
  parameter int CW  = 2,
  parameter int THR = 4
) (
  input  logic [CW-1:0]    p_nref,
  input  logic [CW-1:0]    q_nref,
  input  logic [NL*RW-1:0] p_ref,
  input  logic [NL*RW-1:0] q_ref,
  input  logic [NL*MW-1:0] p_mvx,
  input  logic [NL*MW-1:0] p_mvy,
  input  logic [NL*MW-1:0] q_mvx,
  input  logic [NL*MW-1:0] q_mvy,
  output logic             motion_diff
);
  logic [NL-1:0] lst_on, ref_ne, mv_far;

  for (genvar gi = 0; gi < NL; gi++) begin : g_list
    assign lst_on[gi] = {1'b0, p_nref} > (CW+1)'(gi);
    assign ref_ne[gi] = p_ref[gi*RW +: RW] != q_ref[gi*RW +: RW];

    es_mv_cmp #(.MW(MW), .THR(THR)) u_mv (
      .a_x (p_mvx[gi*MW +: MW]),
      .a_y (p_mvy[gi*MW +: MW]),
      .b_x (q_mvx[gi*MW +: MW]),
      .b_y (q_mvy[gi*MW +: MW]),
      .far (mv_far[gi])
    );
  end

  always_comb begin
    motion_diff = (p_nref != q_nref) || (|(lst_on & (ref_ne | mv_far)));
  end
endmodule

// File: rtl/es_decide.sv
// Priority-ordered strength decision.
module es_decide
  import edge_strength_pkg::*;
(
  input  logic mb_edge,
  input  logic pic_edge,
  input  logic filt_off,
  input  logic any_intra,
  input  logic any_coded,
  input  logic motion_diff,
  output bs_t  bs
);
  always_comb begin
    if (pic_edge || filt_off) bs = BS_NONE;
    else if (any_intra)       bs = mb_edge ? BS_INTRA_MB : BS_INTRA_IN;
    else if (any_coded)       bs = BS_CODED;
    else if (motion_diff)     bs = BS_MOTION;
    else                      bs = BS_NONE;
  end
endmodule

// File: rtl/edge_strength_unit.sv
module edge_strength_unit
  import edge_strength_pkg::*;
#(
  parameter int NL  = 2,
  parameter int RW  = 5,
  parameter int MW  = 12,
  parameter int CW  = 2,
  parameter int THR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_vld,
  input  logic             mb_edge,
  input  logic             pic_edge,
  input  logic             filt_off,
  input  logic             p_intra,
  input  logic             q_intra,
  input  logic             p_coded,
  input  logic             q_coded,
  input  logic [CW-1:0]    p_nref,
  input  logic [CW-1:0]    q_nref,
  input  logic [NL*RW-1:0] p_ref,
  input  logic [NL*RW-1:0] q_ref,
  input  logic [NL*MW-1:0] p_mvx,
  input  logic [NL*MW-1:0] p_mvy,
  input  logic [NL*MW-1:0] q_mvx,
  input  logic [NL*MW-1:0] q_mvy,
  output logic [BS_W-1:0]  bs_luma,
  output logic [BS_W-1:0]  bs_chroma
);
  logic rst_sync_n;
  logic motion_diff;
  bs_t  bs_comb;
  bs_t  bs_q, bs_d;

  es_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  es_motion_cmp #(.NL(NL), .RW(RW), .MW(MW), .CW(CW), .THR(THR)) u_motion (
    .p_nref      (p_nref),
    .q_nref      (q_nref),
    .p_ref       (p_ref),
    .q_ref       (q_ref),
    .p_mvx       (p_mvx),
    .p_mvy       (p_mvy),
    .q_mvx       (q_mvx),
    .q_mvy       (q_mvy),
    .motion_diff (motion_diff)
  );

  es_decide u_decide (
    .mb_edge     (mb_edge),
    .pic_edge    (pic_edge),
    .filt_off    (filt_off),
    .any_intra   (p_intra | q_intra),
    .any_coded   (p_coded | q_coded),
    .motion_diff (motion_diff),
    .bs          (bs_comb)
  );

  always_comb begin
    bs_d = bs_q;
    if (edge_vld) bs_d = bs_comb;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bs_q <= BS_NONE;
    else             bs_q <= bs_d;
  end

  assign bs_luma   = bs_q;
  assign bs_chroma = bs_q;
endmodule

// File: rtl/edge_strength_unit_chk.sv
module edge_strength_unit_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       edge_vld,
  input logic       mb_edge,
  input logic       pic_edge,
  input logic       filt_off,
  input logic       p_intra,
  input logic       q_intra,
  input logic       p_coded,
  input logic       q_coded,
  input logic [2:0] bs_luma,
  input logic [2:0] bs_chroma
);
  a_r1_intra_border: assert property (@(posedge clk) disable iff (!rst_sync_n)
    edge_vld && !pic_edge && !filt_off && (p_intra || q_intra) && mb_edge
    |=> bs_luma == 3'd4);

  a_r2_intra_inner: assert property (@(posedge clk) disable iff (!rst_sync_n)
    edge_vld && !pic_edge && !filt_off && (p_intra || q_intra) && !mb_edge
    |=> bs_luma == 3'd3);

  a_r3_coded: assert property (@(posedge clk) disable iff (!rst_sync_n)
    edge_vld && !pic_edge && !filt_off && !p_intra && !q_intra && (p_coded || q_coded)
    |=> bs_luma == 3'd2);

  a_r6_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bs_luma <= 3'd4);

  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    edge_vld && (pic_edge || filt_off) |=> bs_luma == 3'd0);

  a_r8_chroma: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bs_chroma == bs_luma);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !edge_vld |=> $stable(bs_luma));
endmodule

bind edge_strength_unit edge_strength_unit_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .edge_vld   (edge_vld),
  .mb_edge    (mb_edge),
  .pic_edge   (pic_edge),
  .filt_off   (filt_off),
  .p_intra    (p_intra),
  .q_intra    (q_intra),
  .p_coded    (p_coded),
  .q_coded    (q_coded),
  .bs_luma    (bs_luma),
  .bs_chroma  (bs_chroma)
);

// File: tb/edge_strength_unit_test.sv
module edge_strength_unit_test;
  localparam int NL = 2, RW = 5, MW = 12, CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edge_vld = 1'b0, mb_edge = 1'b0, pic_edge = 1'b0, filt_off = 1'b0;
  logic p_intra = 1'b0, q_intra = 1'b0, p_coded = 1'b0, q_coded = 1'b0;
  logic [CW-1:0]    p_nref = '0, q_nref = '0;
  logic [NL*RW-1:0] p_ref = '0, q_ref = '0;
  logic [NL*MW-1:0] p_mvx = '0, p_mvy = '0, q_mvx = '0, q_mvy = '0;
  logic [2:0] bs_luma, bs_chroma;

  int total = 0;
  int bad = 0;
  int expv = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_strength_unit uut (
    .clk(clk), .rst_n(rst_n), .edge_vld(edge_vld), .mb_edge(mb_edge),
    .pic_edge(pic_edge), .filt_off(filt_off), .p_intra(p_intra), .q_intra(q_intra),
    .p_coded(p_coded), .q_coded(q_coded), .p_nref(p_nref), .q_nref(q_nref),
    .p_ref(p_ref), .q_ref(q_ref), .p_mvx(p_mvx), .p_mvy(p_mvy),
    .q_mvx(q_mvx), .q_mvy(q_mvy), .bs_luma(bs_luma), .bs_chroma(bs_chroma)
  );

  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int model();
    if (pic_edge || filt_off) return 0;                 // R7
    if (p_intra || q_intra) return mb_edge ? 4 : 3;     // R1, R2
    if (p_coded || q_coded) return 2;                   // R3
    if (p_nref != q_nref) return 1;                     // R4
    for (int i = 0; i < NL; i++) begin
      if (i < int'(p_nref)) begin
        int ax, bx, ay, by;
        if (p_ref[i*RW +: RW] != q_ref[i*RW +: RW]) return 1;   // R4
        ax = $signed(p_mvx[i*MW +: MW]); bx = $signed(q_mvx[i*MW +: MW]);
        ay = $signed(p_mvy[i*MW +: MW]); by = $signed(q_mvy[i*MW +: MW]);
        if (absi(ax - bx) >= 4 || absi(ay - by) >= 4) return 1; // R5
      end
    end
    return 0;                                           // R6
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    mb_edge = 0; pic_edge = 0; filt_off = 0;
    p_intra = 0; q_intra = 0; p_coded = 0; q_coded = 0;
    p_nref = 2'd1; q_nref = 2'd1; p_ref = '0; q_ref = '0;
    p_mvx = '0; p_mvy = '0; q_mvx = '0; q_mvy = '0;
  endtask

  // Load the current inputs, then check both outputs one clock later.
  task automatic apply(string req, int exp_dir);
    edge_vld = 1'b1;
    expv = model();
    @(posedge clk);
    @(negedge clk);
    edge_vld = 1'b0;
    check(req, int'(bs_luma), exp_dir);
    check("R8", int'(bs_chroma), int'(bs_luma));
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd7331));
    clear_in();
    repeat (3) @(negedge clk);
    check("R10", int'(bs_luma), 0);
    check("R10", int'(bs_chroma), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", int'(bs_luma), 0);

    clear_in(); p_intra = 1; mb_edge = 1;          apply("R1", 4);
    clear_in(); q_intra = 1; mb_edge = 0;          apply("R2", 3);
    clear_in(); q_intra = 1; p_coded = 1; mb_edge = 1; pic_edge = 1; apply("R7", 0);
    clear_in(); p_intra = 1; filt_off = 1;         apply("R7", 0);
    clear_in(); q_coded = 1;                       apply("R3", 2);
    clear_in(); p_ref[4:0] = 5'd3;                 apply("R4", 1);
    clear_in(); q_nref = 2'd2;                     apply("R4", 1);
    clear_in();                                    apply("R6", 0);
    clear_in(); p_mvx[11:0] = 12'd4;               apply("R5", 1);
    clear_in(); p_mvx[11:0] = 12'd3;               apply("R5", 0);
    clear_in(); q_mvy[11:0] = 12'd4;               apply("R5", 1);
    clear_in(); p_mvy[11:0] = 12'hFFD;             apply("R5", 0);
    clear_in(); p_mvx[11:0] = 12'hFFE; q_mvx[11:0] = 12'd2; apply("R5", 1);
    clear_in(); p_mvx[23:12] = 12'd40; p_ref[9:5] = 5'd7; apply("R5", 0);
    clear_in(); p_nref = 2'd2; q_nref = 2'd2; p_mvy[23:12] = 12'd9; apply("R5", 1);

    // R9: hold while edge_vld is low
    clear_in(); p_intra = 1; mb_edge = 1; apply("R9", 4);
    clear_in();
    repeat (3) @(negedge clk);
    check("R9", int'(bs_luma), 4);

    // Random mix
    expv = 4;
    for (int n = 0; n < 400; n++) begin
      int b, d;
      logic vld;
      vld      = ($urandom % 8) != 0;
      mb_edge  = $urandom % 2;
      pic_edge = ($urandom % 16) == 0;
      filt_off = ($urandom % 16) == 0;
      p_intra  = ($urandom % 10) == 0;
      q_intra  = ($urandom % 10) == 0;
      p_coded  = ($urandom % 5) == 0;
      q_coded  = ($urandom % 5) == 0;
      p_nref   = CW'(1 + $urandom % 2);
      q_nref   = (($urandom % 6) == 0) ? CW'(1 + $urandom % 2) : p_nref;
      for (int i = 0; i < NL; i++) begin
        b = int'($urandom % 3);
        p_ref[i*RW +: RW] = RW'(b);
        q_ref[i*RW +: RW] = (($urandom % 5) == 0) ? RW'($urandom % 3) : RW'(b);
        b = int'($urandom % 64) - 32;
        d = int'($urandom % 11) - 5;
        p_mvx[i*MW +: MW] = MW'(b); q_mvx[i*MW +: MW] = MW'(b + d);
        b = int'($urandom % 64) - 32;
        d = int'($urandom % 11) - 5;
        p_mvy[i*MW +: MW] = MW'(b); q_mvy[i*MW +: MW] = MW'(b + d);
      end
      edge_vld = vld;
      if (vld) expv = model();
      @(posedge clk);
      @(negedge clk);
      check("R6 random", int'(bs_luma), expv);
      check("R8 random", int'(bs_chroma), expv);
    end
    edge_vld = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule